// File: doc/BRIEF.md
# Enclave Tracking Request Checker

This block decides whether a privileged request to start a new tracking cycle on a protected page may go ahead. A request names a 64-bit target page address. The block checks that address against the caller's privilege level and against the protected memory window. It then reads the page's metadata and the metadata's owner control record through two lookup ports. Each lookup has a latency of one cycle.

Every request ends with a single completion pulse. That pulse carries exactly one of three outcomes: a fault, a 64-bit result code with a set of status flags, or a hypervisor exit record. The checks run in a fixed order, and the first one that fails decides the outcome. When virtualization is active and the extension is enabled, the two contention checks on the owner record produce a hypervisor exit instead of an error code. The exit carries a 2-bit qualification and the record's context value as its guest-physical address. Its error value and guest-linear address are implied to be zero.

Top module: `trackReqChecker`

## Requirements
- R1: A target address whose low 12 bits are not all zero raises a general-protection fault (fault code 1). The completion comes one cycle after the request, and no lookup is issued.
- R2: A privilege level other than 0 raises a general-protection fault (fault code 1) one cycle after the request.
- R3: A target address below the window base, or at or above the window limit (the limit is exclusive), raises a page fault (fault code 2). The faulting address is reported on `faultAddr`, one cycle after the request.
- R4: If `pageBusy` is high when the request is accepted, the result is code 7 with ZF=1 and CF=0. This result comes one cycle after the request, and no lookup is issued.
- R5: Otherwise `metaReq` pulses for one cycle with `metaAddr` equal to the target. The metadata is sampled one cycle after that pulse. If its valid bit is 0, the result is code 6 with ZF=1 and CF=0, three cycles after the request.
- R6: The page type is a 3-bit field. Types 2 (regular), 1 (thread control) and 4 (trimmed) fetch the owner record at the owner address from the metadata. Type 0 (control record) fetches the owner record at the target address itself. The fetch is a one-cycle `ownReq` pulse.
- R7: Any other page type (3, 5, 6, 7) returns code 27 with ZF=0 and CF=1, three cycles after the request.
- R8: If the owner record reports the tracking facility as in use, the result is code 7 with ZF=1 and CF=0. When `virtMode` and `extEnable` are both high, a hypervisor exit with qualification 0 and guest-physical address equal to the record's context value is produced instead. Either outcome comes five cycles after the request.
- R9: If the owner record's tracking field is nonzero, the result is code 17 with ZF=1 and CF=0. When `virtMode` and `extEnable` are both high, an exit with qualification 1 is produced instead. The tracking-in-use check takes priority over this one.
- R10: If every check passes, the result is code 0 with ZF=0 and CF=0, five cycles after the request. PF, AF, OF and SF are 0 on every result.
- R11: Each accepted request produces exactly one `done` pulse. At that pulse exactly one of fault (nonzero `fault`), `resultValid` and `exitValid` is set. A `reqValid` that arrives while a request is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | 64 | Target page address |
| reqPriv | input | 2 | Privilege level of the caller |
| protBase | input | 64 | Protected window base (inclusive) |
| protLimit | input | 64 | Protected window limit (exclusive) |
| pageBusy | input | 1 | Target page is being modified by another operation |
| virtMode | input | 1 | Caller runs under a hypervisor |
| extEnable | input | 1 | Hypervisor extension enabled |
| metaReq | output | 1 | Metadata lookup strobe |
| metaAddr | output | 64 | Metadata lookup address |
| metaValid | input | 1 | Metadata valid bit |
| metaType | input | 3 | Metadata page type |
| metaOwner | input | 64 | Metadata owner record address |
| ownReq | output | 1 | Owner record lookup strobe |
| ownAddr | output | 64 | Owner record lookup address |
| ownTrackBusy | input | 1 | Another operation is using the tracking facility |
| ownTracking | input | 8 | Owner record tracking field |
| ownContext | input | 64 | Owner record context value |
| done | output | 1 | Completion pulse |
| fault | output | 2 | 0 none, 1 general protection, 2 page fault |
| faultAddr | output | 64 | Faulting address for a page fault |
| resultValid | output | 1 | Result code and flags are valid |
| resultCode | output | 64 | Result code |
| zf | output | 1 | Zero flag |
| cf | output | 1 | Carry flag |
| pf | output | 1 | Parity flag |
| af | output | 1 | Adjust flag |
| of | output | 1 | Overflow flag |
| sf | output | 1 | Sign flag |
| exitValid | output | 1 | Hypervisor exit produced |
| exitQual | output | 2 | 0 resource conflict, 1 reference conflict |
| exitGpa | output | 64 | Exit guest-physical address |

## Verification
Random requests are spread across the whole decision tree. They vary the address offset, whether the address falls inside the window, privilege, page busy, metadata valid bit, all eight page types, owner busy, the tracking field, and both virtualization inputs. Directed cases pin down the boundaries:
- the window base and the last page before the limit, which separate the in-range address from the page fault;
- an owner record that is both in use and incomplete, which shows the priority between those two checks;
- a control-record page, which shows the target itself used as the owner address;
- virtualization with the extension disabled, which shows that the exit needs both inputs high;
- a second request sent while a request is in progress, which shows that it is ignored.

Completion latency is checked on every request, so a check run in the wrong stage shows up even when the code is right.

// File: rtl/trkPkg.sv
package trkPkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_PF   = 2'd2
  } faultT;

  localparam logic [2:0] PG_OWNER   = 3'd0;
  localparam logic [2:0] PG_THREAD  = 3'd1;
  localparam logic [2:0] PG_REGULAR = 3'd2;
  localparam logic [2:0] PG_TRIMMED = 3'd4;

  localparam int unsigned CODE_OK         = 0;
  localparam int unsigned CODE_INVALID    = 6;
  localparam int unsigned CODE_CONFLICT   = 7;
  localparam int unsigned CODE_INCOMPLETE = 17;
  localparam int unsigned CODE_NOT_REQ    = 27;

  typedef enum logic [3:0] {
    OC_GP, OC_PF, OC_PAGE_CONFLICT, OC_INVALID, OC_NOT_REQ,
    OC_TRK_CONFLICT, OC_INCOMPLETE, OC_OK, OC_EXIT_RES, OC_EXIT_REF
  } outcomeT;

  typedef struct packed {
    logic    issueMeta;
    logic    issueOwn;
    logic    ownFromMeta;
    logic    finish;
    outcomeT outcome;
  } ctrlStrobeT;
endpackage

// File: rtl/trkCtrl.sv
module trkCtrl
  import trkPkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int TRK_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqPriv,
  input  logic [ADDR_W-1:0] protBase,
  input  logic [ADDR_W-1:0] protLimit,
  input  logic              pageBusy,
  input  logic              metaValid,
  input  logic [2:0]        metaType,
  input  logic              ownTrackBusy,
  input  logic [TRK_W-1:0]  ownTracking,
  input  logic              virtMode,
  input  logic              extEnable,
  output ctrlStrobeT        strb
);
  typedef enum logic [2:0] {S_IDLE, S_MWAIT, S_MCHK, S_OWAIT, S_OCHK} stateT;
  stateT state, stateNxt;

  logic misaligned, outOfRange, divertExit;
  assign misaligned = |reqAddr[PAGE_SHIFT-1:0];
  assign outOfRange = (reqAddr < protBase) || (reqAddr >= protLimit);
  assign divertExit = virtMode && extEnable;

  always_comb begin
    stateNxt = state;
    strb = '{issueMeta: 1'b0, issueOwn: 1'b0, ownFromMeta: 1'b0,
             finish: 1'b0, outcome: OC_OK};
    unique case (state)
      S_IDLE: if (reqValid) begin
        if (misaligned || reqPriv != 2'd0) begin
          strb.finish = 1'b1; strb.outcome = OC_GP;
        end else if (outOfRange) begin
          strb.finish = 1'b1; strb.outcome = OC_PF;
        end else if (pageBusy) begin
          strb.finish = 1'b1; strb.outcome = OC_PAGE_CONFLICT;
        end else begin
          strb.issueMeta = 1'b1; stateNxt = S_MWAIT;
        end
      end
      S_MWAIT: stateNxt = S_MCHK;
      S_MCHK: begin
        stateNxt = S_IDLE;
        if (!metaValid) begin
          strb.finish = 1'b1; strb.outcome = OC_INVALID;
        end else if (metaType == PG_REGULAR || metaType == PG_THREAD ||
                     metaType == PG_TRIMMED) begin
          strb.issueOwn = 1'b1; strb.ownFromMeta = 1'b1; stateNxt = S_OWAIT;
        end else if (metaType == PG_OWNER) begin
          strb.issueOwn = 1'b1; stateNxt = S_OWAIT;
        end else begin
          strb.finish = 1'b1; strb.outcome = OC_NOT_REQ;
        end
      end
      S_OWAIT: stateNxt = S_OCHK;
      S_OCHK: begin
        stateNxt = S_IDLE;
        strb.finish = 1'b1;
        if (ownTrackBusy)
          strb.outcome = divertExit ? OC_EXIT_RES : OC_TRK_CONFLICT;
        else if (|ownTracking)
          strb.outcome = divertExit ? OC_EXIT_REF : OC_INCOMPLETE;
        else
          strb.outcome = OC_OK;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  // R11: a request seen mid-operation must not start or finish anything
  a_r11_busy_ignores_req: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_MWAIT || state == S_OWAIT) |-> !strb.finish && !strb.issueMeta);
endmodule

// File: rtl/trkData.sv
module trkData
  import trkPkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CODE_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] metaOwner,
  input  logic [63:0]       ownContext,
  output logic              metaReq,
  output logic [ADDR_W-1:0] metaAddr,
  output logic              ownReq,
  output logic [ADDR_W-1:0] ownAddr,
  output logic              done,
  output logic [1:0]        fault,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              resultValid,
  output logic [CODE_W-1:0] resultCode,
  output logic              zf,
  output logic              cf,
  output logic              pf,
  output logic              af,
  output logic              of,
  output logic              sf,
  output logic              exitValid,
  output logic [1:0]        exitQual,
  output logic [63:0]       exitGpa
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      metaReq <= 1'b0; metaAddr <= '0; ownReq <= 1'b0; ownAddr <= '0;
      done <= 1'b0; fault <= FLT_NONE; faultAddr <= '0;
      resultValid <= 1'b0; resultCode <= '0;
      {zf, cf, pf, af, of, sf} <= '0;
      exitValid <= 1'b0; exitQual <= '0; exitGpa <= '0;
    end else begin
      metaReq <= strb.issueMeta;
      ownReq  <= strb.issueOwn;
      done    <= strb.finish;
      if (strb.issueMeta) metaAddr <= reqAddr;
      if (strb.issueOwn)  ownAddr  <= strb.ownFromMeta ? metaOwner : metaAddr;
      if (strb.finish) begin
        fault <= FLT_NONE; resultValid <= 1'b0; exitValid <= 1'b0;
        resultCode <= '0; exitQual <= '0; exitGpa <= '0;
        {zf, cf, pf, af, of, sf} <= '0;
        unique case (strb.outcome)
          OC_GP: fault <= FLT_GP;
          OC_PF: begin fault <= FLT_PF; faultAddr <= reqAddr; end
          OC_PAGE_CONFLICT, OC_TRK_CONFLICT: begin
            resultValid <= 1'b1; resultCode <= CODE_W'(CODE_CONFLICT); zf <= 1'b1;
          end
          OC_INVALID: begin
            resultValid <= 1'b1; resultCode <= CODE_W'(CODE_INVALID); zf <= 1'b1;
          end
          OC_INCOMPLETE: begin
            resultValid <= 1'b1; resultCode <= CODE_W'(CODE_INCOMPLETE); zf <= 1'b1;
          end
          OC_NOT_REQ: begin
            resultValid <= 1'b1; resultCode <= CODE_W'(CODE_NOT_REQ); cf <= 1'b1;
          end
          OC_OK: resultValid <= 1'b1;
          OC_EXIT_RES: begin exitValid <= 1'b1; exitQual <= 2'd0; exitGpa <= ownContext; end
          OC_EXIT_REF: begin exitValid <= 1'b1; exitQual <= 2'd1; exitGpa <= ownContext; end
          default: fault <= FLT_NONE;
        endcase
      end
    end
  end

  // R5: metadata strobe lasts one cycle
  a_r5_meta_pulse: assert property (@(posedge clk) disable iff (!rstN)
    metaReq |=> !metaReq);
  // R6: owner strobe lasts one cycle
  a_r6_own_pulse: assert property (@(posedge clk) disable iff (!rstN)
    ownReq |=> !ownReq);
endmodule

// File: rtl/trackReqChecker.sv
module trackReqChecker
  import trkPkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int TRK_W      = 8,
  parameter int CODE_W     = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqPriv,
  input  logic [ADDR_W-1:0] protBase,
  input  logic [ADDR_W-1:0] protLimit,
  input  logic              pageBusy,
  input  logic              virtMode,
  input  logic              extEnable,
  output logic              metaReq,
  output logic [ADDR_W-1:0] metaAddr,
  input  logic              metaValid,
  input  logic [2:0]        metaType,
  input  logic [ADDR_W-1:0] metaOwner,
  output logic              ownReq,
  output logic [ADDR_W-1:0] ownAddr,
  input  logic              ownTrackBusy,
  input  logic [TRK_W-1:0]  ownTracking,
  input  logic [63:0]       ownContext,
  output logic              done,
  output logic [1:0]        fault,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              resultValid,
  output logic [CODE_W-1:0] resultCode,
  output logic              zf,
  output logic              cf,
  output logic              pf,
  output logic              af,
  output logic              of,
  output logic              sf,
  output logic              exitValid,
  output logic [1:0]        exitQual,
  output logic [63:0]       exitGpa
);
  ctrlStrobeT strb;

  trkCtrl #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .TRK_W(TRK_W)) ctrl_i (
    .clk, .rstN, .reqValid, .reqAddr, .reqPriv, .protBase, .protLimit,
    .pageBusy, .metaValid, .metaType, .ownTrackBusy, .ownTracking,
    .virtMode, .extEnable, .strb
  );

  trkData #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) data_i (
    .clk, .rstN, .strb, .reqAddr, .metaOwner, .ownContext,
    .metaReq, .metaAddr, .ownReq, .ownAddr, .done, .fault, .faultAddr,
    .resultValid, .resultCode, .zf, .cf, .pf, .af, .of, .sf,
    .exitValid, .exitQual, .exitGpa
  );

  // R11: one outcome class per completion
  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $countones({fault != 2'd0, resultValid, exitValid}) == 1);
  // R1: faults complete the cycle after the request
  a_r1_fault_direct: assert property (@(posedge clk) disable iff (!rstN)
    (done && fault != 2'd0) |-> $past(reqValid));
  // R5: an invalid-page result follows a metadata lookup
  a_r5_invalid_after_lookup: assert property (@(posedge clk) disable iff (!rstN)
    (done && resultValid && resultCode == CODE_W'(6) && !zf == 1'b0 && !$past(reqValid))
      |-> $past(metaReq, 2));
  // R8: an exit follows an owner lookup
  a_r8_exit_after_owner: assert property (@(posedge clk) disable iff (!rstN)
    (done && exitValid) |-> $past(ownReq, 2));
endmodule

// File: tb/trackReqChecker_tb_top.sv
`timescale 1ns/1ps
module trackReqChecker_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic reqValid = 1'b0;
  logic [63:0] reqAddr = '0;
  logic [1:0] reqPriv = '0;
  logic [63:0] protBase = 64'h0000_0000_1000_0000;
  logic [63:0] protLimit = 64'h0000_0000_1100_0000;
  logic pageBusy = 1'b0, virtMode = 1'b0, extEnable = 1'b0;
  logic metaReq, ownReq, done, resultValid, exitValid;
  logic [63:0] metaAddr, ownAddr, faultAddr, resultCode, exitGpa;
  logic metaValid = 1'b0;
  logic [2:0] metaType = '0;
  logic [63:0] metaOwner = '0;
  logic ownTrackBusy = 1'b0;
  logic [7:0] ownTracking = '0;
  logic [63:0] ownContext = '0;
  logic [1:0] fault, exitQual;
  logic zf, cf, pf, af, of, sf;

  // lookup contents chosen per test
  logic tMv, tOwnBusy;
  logic [2:0] tType;
  logic [63:0] tOwner, tCtx, seenMeta, seenOwn;
  logic [7:0] tTrk;

  int checks = 0, errors = 0;

  trackReqChecker dut_i (
    .clk, .rstN, .reqValid, .reqAddr, .reqPriv, .protBase, .protLimit,
    .pageBusy, .virtMode, .extEnable, .metaReq, .metaAddr, .metaValid,
    .metaType, .metaOwner, .ownReq, .ownAddr, .ownTrackBusy, .ownTracking,
    .ownContext, .done, .fault, .faultAddr, .resultValid, .resultCode,
    .zf, .cf, .pf, .af, .of, .sf, .exitValid, .exitQual, .exitGpa
  );

  // one-cycle lookup responders
  always @(posedge clk) begin
    if (metaReq) begin
      metaValid <= tMv; metaType <= tType; metaOwner <= tOwner; seenMeta <= metaAddr;
    end
    if (ownReq) begin
      ownTrackBusy <= tOwnBusy; ownTracking <= tTrk; ownContext <= tCtx; seenOwn <= ownAddr;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected outcome
  logic [1:0] eFault, eQual;
  logic eRes, eExit, eZf, eCf;
  logic [63:0] eCode, eOwn, eGpa;
  int eLat;
  string eReq;

  task automatic predict(input logic [63:0] a, input logic [1:0] pr, input logic busy);
    eFault = 0; eRes = 0; eExit = 0; eZf = 0; eCf = 0; eCode = 0; eQual = 0; eGpa = 0;
    eOwn = 0; eLat = 1;
    if (a[11:0] != 0)               begin eFault = 1; eReq = "R1"; end
    else if (pr != 0)               begin eFault = 1; eReq = "R2"; end
    else if (a < protBase || a >= protLimit) begin eFault = 2; eReq = "R3"; end
    else if (busy) begin eRes = 1; eCode = 7; eZf = 1; eReq = "R4"; end
    else begin
      eLat = 3;
      if (!tMv) begin eRes = 1; eCode = 6; eZf = 1; eReq = "R5"; end
      else if (tType == 3'd0 || tType == 3'd1 || tType == 3'd2 || tType == 3'd4) begin
        eLat = 5;
        eOwn = (tType == 3'd0) ? a : tOwner;
        if (tOwnBusy) begin
          eReq = "R8";
          if (virtMode && extEnable) begin eExit = 1; eQual = 0; eGpa = tCtx; end
          else begin eRes = 1; eCode = 7; eZf = 1; end
        end else if (tTrk != 0) begin
          eReq = "R9";
          if (virtMode && extEnable) begin eExit = 1; eQual = 1; eGpa = tCtx; end
          else begin eRes = 1; eCode = 17; eZf = 1; end
        end else begin eRes = 1; eReq = "R10"; end
      end else begin eRes = 1; eCode = 27; eCf = 1; eReq = "R7"; end
    end
  endtask

  task automatic runReq(input logic [63:0] a, input logic [1:0] pr, input logic busy,
                        input bit spurious);
    int n = 0;
    int dones = 0;
    int lat = 0;
    predict(a, pr, busy);
    @(negedge clk);
    reqAddr = a; reqPriv = pr; pageBusy = busy; reqValid = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); #1;
      n++;
      if (n == 1) reqValid = 1'b0;
      if (spurious && n == 2) begin reqValid = 1'b1; reqPriv = 2'd3; end
      if (spurious && n == 3) reqValid = 1'b0;
      if (done) begin
        dones++;
        if (dones == 1) begin
          lat = n;
          chk({eReq, " fault"}, 64'(fault), 64'(eFault));
          chk({eReq, " resultValid"}, 64'(resultValid), 64'(eRes));
          chk({eReq, " exitValid"}, 64'(exitValid), 64'(eExit));
          if (eFault == 2) chk("R3 faultAddr", faultAddr, a);
          if (eRes) begin
            chk({eReq, " code"}, resultCode, eCode);
            chk({eReq, " zf"}, 64'(zf), 64'(eZf));
            chk({eReq, " cf"}, 64'(cf), 64'(eCf));
            chk("R10 pf/af/of/sf", 64'({pf, af, of, sf}), 64'd0);
          end
          if (eExit) begin
            chk({eReq, " exitQual"}, 64'(exitQual), 64'(eQual));
            chk({eReq, " exitGpa"}, exitGpa, eGpa);
          end
          if (eLat >= 3) chk("R5 metaAddr", seenMeta, a);
          if (eLat == 5) chk("R6 ownAddr", seenOwn, eOwn);
        end
      end
      if (!spurious && dones == 1 && n >= eLat + 2) break;
    end
    chk({eReq, " latency"}, 64'(lat), 64'(eLat));
    chk("R11 single done", 64'(dones), 64'd1);
  endtask

  function automatic logic [63:0] pageIn(input int unsigned k);
    return protBase + 64'(k % 32'h1000) * 64'h1000;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7919));
    tMv = 1; tType = 2; tOwner = 64'h2000; tOwnBusy = 0; tTrk = 0; tCtx = 64'hABCD;
    seenMeta = '0; seenOwn = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset done", 64'(done), 64'd0);
    chk("R11 reset fault", 64'(fault), 64'd0);
    chk("R11 reset result", 64'({resultValid, exitValid}), 64'd0);
    @(negedge clk); rstN = 1'b1;

    // directed
    runReq(protBase + 64'h10, 0, 0, 0);                  // R1
    runReq(protBase, 2'd3, 0, 0);                         // R2
    runReq(protBase - 64'h1000, 0, 0, 0);                 // R3 below
    runReq(protLimit, 0, 0, 0);                           // R3 at limit
    runReq(protLimit - 64'h1000, 0, 1, 0);                // R4 last page
    tMv = 0; runReq(protBase, 0, 0, 0); tMv = 1;          // R5
    tType = 3'd5; runReq(protBase, 0, 0, 0);              // R7
    tType = 3'd0; runReq(pageIn(9), 0, 0, 0);             // R6 self owner, R10
    tType = 3'd4; tOwnBusy = 1; tTrk = 3;                 // R8 priority over R9
    runReq(pageIn(3), 0, 0, 0);
    virtMode = 1; extEnable = 0; runReq(pageIn(3), 0, 0, 0);
    extEnable = 1; runReq(pageIn(3), 0, 0, 0);            // R8 exit
    tOwnBusy = 0; runReq(pageIn(4), 0, 0, 0);             // R9 exit
    virtMode = 0; extEnable = 0;
    tTrk = 0; tType = 3'd2; runReq(pageIn(5), 0, 0, 1);   // R11 spurious ignored

    // random
    for (int i = 0; i < 300; i++) begin
      logic [63:0] a;
      logic [1:0] pr;
      int unsigned sel = $urandom % 16;
      a = pageIn($urandom);
      if (sel == 0) a = a + 64'($urandom % 4095 + 1);
      if (sel == 1) a = protLimit + 64'($urandom % 64) * 64'h1000;
      if (sel == 2) a = protBase - 64'($urandom % 64 + 1) * 64'h1000;
      pr = ($urandom % 10 == 0) ? 2'($urandom % 3 + 1) : 2'd0;
      tMv = ($urandom % 8) != 0;
      tType = 3'($urandom);
      tOwner = pageIn($urandom);
      tOwnBusy = ($urandom % 4) == 0;
      tTrk = ($urandom % 3 == 0) ? 8'($urandom) : 8'd0;
      tCtx = {$urandom, $urandom};
      virtMode = 1'($urandom); extEnable = 1'($urandom);
      runReq(a, pr, ($urandom % 8) == 0, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule